// File: doc/BRIEF.md
# SIMT Divergence Reconvergence Stack

This block tracks the control flow of a single warp whose lanes (32 by default) share one program counter. It holds the warp PC and an active-lane mask. It also holds a last-in-first-out store of deferred paths, and each stored path carries its own join PC. When a branch resolves, the block compares the per-lane taken bits against the current mask. If every active lane agrees, only the PC moves. If the lanes disagree, the taken lanes run first. The fall-through lanes, their start PC, the join PC and the pre-branch mask are saved on the store.

The PC can reach the join PC of the top entry while the taken lanes are still running. In that case the block spends one settle cycle switching to the saved fall-through lanes. When the PC reaches that join PC a second time, the block spends another settle cycle popping the entry and restoring the pre-branch mask. A settle cycle ignores branch and advance inputs and writes nothing back. Outside settle cycles, the write-back enables equal the active mask, so inactive lanes keep their registers. Entries nest to a parameterised depth. A divergent branch that finds the store full is dropped, and a sticky error flag is raised.

Top module: `simt_reconv_stack`

## Requirements
- R1: During and right after reset, the PC equals RESET_PC (default 0) and the mask has every lane set. The settle output and the overflow flag are low, and the write-back enables are all ones.
- R2: An advance (adv_valid with no branch and no settle) loads adv_pc into the PC one cycle later. With no event, the PC and the mask hold.
- R3: A uniform branch changes only the PC and pushes nothing. A branch is uniform when no active lane is taken (PC becomes br_fallthru) or when every active lane is taken (PC becomes br_target).
- R4: A divergent branch has both taken and non-taken active lanes. It sets the PC to br_target and the mask to br_taken AND the old mask. It pushes one entry holding br_fallthru, the non-taken active lanes, br_reconv and the old mask.
- R5: While the PC equals the top entry's join PC and that entry's fall-through side has not yet run, the block settles. After the settle cycle the PC is the saved fall-through PC and the mask is the saved non-taken lanes.
- R6: When the PC equals the top entry's join PC a second time, the settle cycle pops the entry. The PC stays at the join PC and the mask returns to the pre-branch mask.
- R7: In a settle cycle, settle_o is high, wb_en_o is zero, and any branch or advance offered in that cycle has no effect.
- R8: Outside settle cycles, wb_en_o equals the active mask.
- R9: Divergence nests. Each entry is matched only against its own join PC, entries leave in last-in-first-out order, and entries that share a join PC pop one per settle cycle.
- R10: A divergent branch that arrives while DEPTH entries are held leaves the PC and the mask unchanged and sets overflow_o. The flag stays set until reset.
- R11: When a branch and an advance arrive in the same cycle, the branch wins.
- R12: An even/odd lane split runs as two serialised passes, each with exactly half of the lanes active (16 of 32). After the join, all lanes are active again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adv_valid | input | 1 | Sequential PC advance request |
| adv_pc | input | PC_W | Next sequential PC |
| br_valid | input | 1 | Resolved branch present |
| br_taken | input | LANES | Per-lane taken bits |
| br_target | input | PC_W | Taken-path PC |
| br_fallthru | input | PC_W | Not-taken-path PC |
| br_reconv | input | PC_W | Join PC (immediate post-dominator) |
| pc_o | output | PC_W | Current warp PC |
| mask_o | output | LANES | Current active-lane mask |
| wb_en_o | output | LANES | Per-lane register write enables |
| settle_o | output | 1 | Reconvergence settle cycle in progress |
| overflow_o | output | 1 | Sticky divergence-store overflow flag |

## Verification
The bench covers several corner cases, each with its own failure symptom:
- An if-only branch, whose fall-through PC equals its join PC. This forces a switch immediately followed by a pop. A design that compared the PC only on arrival would leave the lane group stranded.
- Two nested branches that share one join PC. A design that popped both in one step would lose the intermediate mask.
- A branch offered during a settle cycle must be ignored. A faulty design would start a bogus path or write back with a stale mask.
- A ninth nested divergence at the default depth. It must leave the PC and the mask untouched and set the sticky flag. Unwinding the eight held entries must then restore the full mask, which exposes any corruption of the lowest slot or wrong LIFO order.

// File: rtl/simt_pkg.sv
package simt_pkg;

  typedef enum logic [1:0] {
    BR_NONE    = 2'd0,
    BR_UNIFORM = 2'd1,
    BR_DIVERGE = 2'd2
  } br_kind_e;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_SWITCH = 2'd1,
    ST_JOIN   = 2'd2
  } settle_kind_e;

endpackage

// File: rtl/simt_branch_split.sv
module simt_branch_split
  import simt_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic             valid,
  input  logic [LANES-1:0] cur_mask,
  input  logic [LANES-1:0] taken,
  output logic [LANES-1:0] taken_lanes,
  output logic [LANES-1:0] fall_lanes,
  output br_kind_e         kind
);

  function automatic logic [LANES-1:0] lanes_taken(input logic [LANES-1:0] m,
                                                   input logic [LANES-1:0] t);
    return m & t;
  endfunction

  function automatic logic [LANES-1:0] lanes_fall(input logic [LANES-1:0] m,
                                                  input logic [LANES-1:0] t);
    return m & ~t;
  endfunction

  function automatic br_kind_e classify(input logic v,
                                        input logic [LANES-1:0] tl,
                                        input logic [LANES-1:0] fl);
    if (!v)                           return BR_NONE;
    else if (tl == '0 || fl == '0)    return BR_UNIFORM;
    else                              return BR_DIVERGE;
  endfunction

  always_comb begin
    taken_lanes = lanes_taken(cur_mask, taken);
    fall_lanes  = lanes_fall(cur_mask, taken);
    kind        = classify(valid, taken_lanes, fall_lanes);
  end

endmodule

// File: rtl/simt_entry_stack.sv
module simt_entry_stack #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  input  logic          upd,
  input  logic [W-1:0]  upd_data,
  output logic [W-1:0]  top_data,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  slots [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                               slot_q <= '0;
      else if (push && cnt_q == CW'(i))         slot_q <= push_data;
      else if (upd && cnt_q == CW'(i + 1))      slot_q <= upd_data;
    end
    assign slots[i] = slot_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (push && !full)     cnt_q <= cnt_q + CW'(1);
    else if (pop && !empty)     cnt_q <= cnt_q - CW'(1);
  end

  always_comb begin
    top_data = '0;
    for (int i = 0; i < DEPTH; i++)
      if (cnt_q == CW'(i + 1)) top_data = slots[i];
  end

  assign count = cnt_q;
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);

endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
  import simt_pkg::*;
#(
  parameter int          LANES    = 32,
  parameter int          PC_W     = 32,
  parameter int          DEPTH    = 8,
  parameter logic [31:0] RESET_PC = 32'd0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_valid,
  input  logic [PC_W-1:0]  adv_pc,
  input  logic             br_valid,
  input  logic [LANES-1:0] br_taken,
  input  logic [PC_W-1:0]  br_target,
  input  logic [PC_W-1:0]  br_fallthru,
  input  logic [PC_W-1:0]  br_reconv,
  output logic [PC_W-1:0]  pc_o,
  output logic [LANES-1:0] mask_o,
  output logic [LANES-1:0] wb_en_o,
  output logic             settle_o,
  output logic             overflow_o
);

  typedef struct packed {
    logic             second;
    logic [LANES-1:0] join_mask;
    logic [LANES-1:0] alt_mask;
    logic [PC_W-1:0]  rpc;
    logic [PC_W-1:0]  alt_pc;
  } ent_t;

  localparam int ENT_W = $bits(ent_t);
  localparam int CW    = $clog2(DEPTH + 1);

  logic [PC_W-1:0]  pc_q, pc_d;
  logic [LANES-1:0] mask_q, mask_d;
  logic             ovf_q, ovf_d;

  logic [LANES-1:0] taken_lanes, fall_lanes;
  br_kind_e         kind;
  settle_kind_e     skind;

  logic [ENT_W-1:0] top_raw;
  ent_t             top_ent, push_ent, upd_ent;
  logic [CW-1:0]    stk_cnt;
  logic             stk_full, stk_empty;

  logic at_rpc, br_go;
  logic evt_switch, evt_join, evt_uniform, evt_diverge, evt_overflow, evt_adv;
  logic [PC_W-1:0] uni_pc;

  simt_branch_split #(.LANES(LANES)) u_split (
    .valid       (br_valid),
    .cur_mask    (mask_q),
    .taken       (br_taken),
    .taken_lanes (taken_lanes),
    .fall_lanes  (fall_lanes),
    .kind        (kind)
  );

  assign top_ent = ent_t'(top_raw);

  always_comb begin
    at_rpc = !stk_empty && (pc_q == top_ent.rpc);
    if (!at_rpc)              skind = ST_RUN;
    else if (!top_ent.second) skind = ST_SWITCH;
    else                      skind = ST_JOIN;
  end

  assign evt_switch   = (skind == ST_SWITCH);
  assign evt_join     = (skind == ST_JOIN);
  assign br_go        = br_valid && !at_rpc;
  assign evt_uniform  = br_go && (kind == BR_UNIFORM);
  assign evt_diverge  = br_go && (kind == BR_DIVERGE) && !stk_full;
  assign evt_overflow = br_go && (kind == BR_DIVERGE) && stk_full;
  assign evt_adv      = adv_valid && !at_rpc && !br_valid;
  assign uni_pc       = (taken_lanes == '0) ? br_fallthru : br_target;

  always_comb begin
    push_ent.second    = 1'b0;
    push_ent.join_mask = mask_q;
    push_ent.alt_mask  = fall_lanes;
    push_ent.rpc       = br_reconv;
    push_ent.alt_pc    = br_fallthru;
    upd_ent            = top_ent;
    upd_ent.second     = 1'b1;
  end

  simt_entry_stack #(.W(ENT_W), .DEPTH(DEPTH)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (evt_diverge),
    .push_data (push_ent),
    .pop       (evt_join),
    .upd       (evt_switch),
    .upd_data  (upd_ent),
    .top_data  (top_raw),
    .count     (stk_cnt),
    .full      (stk_full),
    .empty     (stk_empty)
  );

  always_comb begin
    pc_d   = pc_q;
    mask_d = mask_q;
    ovf_d  = ovf_q | evt_overflow;
    if (evt_switch) begin
      pc_d   = top_ent.alt_pc;
      mask_d = top_ent.alt_mask;
    end else if (evt_join) begin
      mask_d = top_ent.join_mask;
    end else if (evt_diverge) begin
      pc_d   = br_target;
      mask_d = taken_lanes;
    end else if (evt_uniform) begin
      pc_d   = uni_pc;
    end else if (evt_adv) begin
      pc_d   = adv_pc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= RESET_PC[PC_W-1:0];
      mask_q <= '1;
      ovf_q  <= 1'b0;
    end else begin
      pc_q   <= pc_d;
      mask_q <= mask_d;
      ovf_q  <= ovf_d;
    end
  end

  assign pc_o       = pc_q;
  assign mask_o     = mask_q;
  assign settle_o   = at_rpc;
  assign wb_en_o    = at_rpc ? '0 : mask_q;
  assign overflow_o = ovf_q;

endmodule

// File: rtl/simt_reconv_checker.sv
module simt_reconv_checker #(
  parameter int LANES = 32,
  parameter int PC_W  = 32,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             adv_valid,
  input logic             br_valid,
  input logic [LANES-1:0] br_taken,
  input logic [PC_W-1:0]  pc,
  input logic [LANES-1:0] mask,
  input logic [LANES-1:0] wb_en,
  input logic             settle,
  input logic             overflow,
  input logic             evt_uniform,
  input logic             evt_diverge,
  input logic             evt_overflow,
  input logic             evt_switch,
  input logic             evt_join,
  input logic [CW-1:0]    depth,
  input logic [PC_W-1:0]  top_alt_pc,
  input logic [LANES-1:0] top_alt_mask,
  input logic [LANES-1:0] top_join_mask
);

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!settle && !br_valid && !adv_valid) |=> ($stable(pc) && $stable(mask)));

  a_r3_uniform_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    evt_uniform |=> ($stable(mask) && $stable(depth)));

  a_r4_diverge_push: assert property (@(posedge clk) disable iff (!rst_n)
    evt_diverge |=> (mask == ($past(mask) & $past(br_taken))
                     && depth == $past(depth) + CW'(1)));

  a_r4_mask_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    mask != '0);

  a_r5_switch_path: assert property (@(posedge clk) disable iff (!rst_n)
    evt_switch |=> (pc == $past(top_alt_pc) && mask == $past(top_alt_mask)
                    && $stable(depth)));

  a_r6_join_restore: assert property (@(posedge clk) disable iff (!rst_n)
    evt_join |=> (mask == $past(top_join_mask) && $stable(pc)
                  && depth == $past(depth) - CW'(1)));

  a_r7_settle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    settle |-> (wb_en == '0));

  a_r8_wb_follows_mask: assert property (@(posedge clk) disable iff (!rst_n)
    !settle |-> (wb_en == mask));

  a_r9_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CW'(DEPTH));

  a_r10_overflow_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    evt_overflow |=> (overflow && $stable(pc) && $stable(mask) && $stable(depth)));

  a_r10_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

endmodule

bind simt_reconv_stack simt_reconv_checker #(
  .LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .adv_valid     (adv_valid),
  .br_valid      (br_valid),
  .br_taken      (br_taken),
  .pc            (pc_o),
  .mask          (mask_o),
  .wb_en         (wb_en_o),
  .settle        (settle_o),
  .overflow      (overflow_o),
  .evt_uniform   (evt_uniform),
  .evt_diverge   (evt_diverge),
  .evt_overflow  (evt_overflow),
  .evt_switch    (evt_switch),
  .evt_join      (evt_join),
  .depth         (stk_cnt),
  .top_alt_pc    (top_ent.alt_pc),
  .top_alt_mask  (top_ent.alt_mask),
  .top_join_mask (top_ent.join_mask)
);

// File: tb/tb_simt_reconv_stack.sv
`timescale 1ns/1ps
module tb_simt_reconv_stack;

  localparam int L = 32;
  localparam int P = 32;
  localparam int D = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         adv_valid = 1'b0;
  logic [P-1:0] adv_pc = '0;
  logic         br_valid = 1'b0;
  logic [L-1:0] br_taken = '0;
  logic [P-1:0] br_target = '0, br_fallthru = '0, br_reconv = '0;
  logic [P-1:0] pc_o;
  logic [L-1:0] mask_o, wb_en_o;
  logic         settle_o, overflow_o;

  always #2.5 clk = ~clk;

  simt_reconv_stack #(.LANES(L), .PC_W(P), .DEPTH(D)) dut (
    .clk(clk), .rst_n(rst_n), .adv_valid(adv_valid), .adv_pc(adv_pc),
    .br_valid(br_valid), .br_taken(br_taken), .br_target(br_target),
    .br_fallthru(br_fallthru), .br_reconv(br_reconv), .pc_o(pc_o),
    .mask_o(mask_o), .wb_en_o(wb_en_o), .settle_o(settle_o),
    .overflow_o(overflow_o)
  );

  typedef struct packed {
    logic [P-1:0] pc;
    logic [L-1:0] mask;
    logic [L-1:0] wb;
    logic         settle;
    logic         ovf;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    errors = 0;

  // independent model of the requirements
  logic [P-1:0] m_pc;
  logic [L-1:0] m_mask;
  logic         m_ovf;
  int           m_sp;
  logic [P-1:0] s_alt_pc [D];
  logic [L-1:0] s_alt_mask [D];
  logic [P-1:0] s_rpc [D];
  logic [L-1:0] s_join [D];
  logic         s_second [D];

  function automatic logic model_settle();
    return (m_sp > 0) && (m_pc == s_rpc[m_sp-1]);
  endfunction

  task automatic model_step(input logic br, input logic adv, input logic [L-1:0] tk,
                            input logic [P-1:0] tgt, input logic [P-1:0] ft,
                            input logic [P-1:0] rp, input logic [P-1:0] np);
    logic [L-1:0] t, n;
    if (model_settle()) begin
      if (!s_second[m_sp-1]) begin
        m_pc   = s_alt_pc[m_sp-1];
        m_mask = s_alt_mask[m_sp-1];
        s_second[m_sp-1] = 1'b1;
      end else begin
        m_mask = s_join[m_sp-1];
        m_sp   = m_sp - 1;
      end
    end else if (br) begin
      t = tk & m_mask;
      n = ~tk & m_mask;
      if (t == '0)       m_pc = ft;
      else if (n == '0)  m_pc = tgt;
      else if (m_sp == D) m_ovf = 1'b1;
      else begin
        s_alt_pc[m_sp] = ft; s_alt_mask[m_sp] = n; s_rpc[m_sp] = rp;
        s_join[m_sp] = m_mask; s_second[m_sp] = 1'b0;
        m_sp = m_sp + 1;
        m_pc = tgt; m_mask = t;
      end
    end else if (adv) begin
      m_pc = np;
    end
  endtask

  task automatic step(input string tag, input logic br, input logic adv,
                      input logic [L-1:0] tk, input logic [P-1:0] tgt,
                      input logic [P-1:0] ft, input logic [P-1:0] rp,
                      input logic [P-1:0] np);
    exp_t e;
    br_valid = br; adv_valid = adv; br_taken = tk; br_target = tgt;
    br_fallthru = ft; br_reconv = rp; adv_pc = np;
    @(posedge clk);
    model_step(br, adv, tk, tgt, ft, rp, np);
    e.pc = m_pc; e.mask = m_mask; e.settle = model_settle();
    e.wb = e.settle ? '0 : m_mask; e.ovf = m_ovf;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    #1;
    br_valid = 1'b0; adv_valid = 1'b0;
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b0, 1'b0, '0, '0, '0, '0, '0);
  endtask
  task automatic adv(input string tag, input logic [P-1:0] np);
    step(tag, 1'b0, 1'b1, '0, '0, '0, '0, np);
  endtask
  task automatic br(input string tag, input logic [L-1:0] tk, input logic [P-1:0] tgt,
                    input logic [P-1:0] ft, input logic [P-1:0] rp);
    step(tag, 1'b1, 1'b0, tk, tgt, ft, rp, '0);
  endtask

  task automatic direct(input string tag, input logic ok, input logic [63:0] act,
                        input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // monitor: compares each expected state at the falling edge after it was produced
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t  e;
      string tg;
      e  = exp_q.pop_front();
      tg = tag_q.pop_front();
      checks++;
      if (pc_o !== e.pc || mask_o !== e.mask || wb_en_o !== e.wb ||
          settle_o !== e.settle || overflow_o !== e.ovf) begin
        errors++;
        $display("FAIL %s actual pc=%0h mask=%0h wb=%0h settle=%0b ovf=%0b expected pc=%0h mask=%0h wb=%0h settle=%0b ovf=%0b",
                 tg, pc_o, mask_o, wb_en_o, settle_o, overflow_o,
                 e.pc, e.mask, e.wb, e.settle, e.ovf);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_pc = '0; m_mask = '1; m_ovf = 1'b0; m_sp = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    direct("R1 pc", pc_o == '0, 64'(pc_o), 64'h0);
    direct("R1 mask", mask_o == '1, 64'(mask_o), 64'hffffffff);
    direct("R1 wb", wb_en_o == '1, 64'(wb_en_o), 64'hffffffff);
    direct("R1 flags", !settle_o && !overflow_o, {62'd0, settle_o, overflow_o}, 64'h0);
    rst_n = 1'b1;
    idle("R1 after release");

    // R2 sequential advance and hold
    adv("R2 adv", 32'h4);
    adv("R2 adv", 32'h8);
    idle("R2 hold");

    // R3 uniform branches
    br("R3 all taken", 32'hffff_ffff, 32'h40, 32'h44, 32'h80);
    br("R3 none taken", 32'h0, 32'h90, 32'h48, 32'h80);

    // R11 branch beats advance
    step("R11 priority", 1'b1, 1'b1, 32'hffff_ffff, 32'h50, 32'h54, 32'h99, 32'h777);

    // R12 / R4 even-odd split
    br("R4 diverge", 32'h5555_5555, 32'h100, 32'h14, 32'h200);
    @(negedge clk);
    direct("R12 first pass lanes", $countones(mask_o) == 16, 64'($countones(mask_o)), 64'd16);
    adv("R4 taken path", 32'h104);
    adv("R5 arrive", 32'h200);
    br("R7 ignored in settle", 32'h0000_ffff, 32'h999, 32'h998, 32'h997);
    @(negedge clk);
    direct("R12 second pass lanes", $countones(mask_o) == 16, 64'($countones(mask_o)), 64'd16);
    direct("R5 alt mask", mask_o == 32'haaaa_aaaa, 64'(mask_o), 64'haaaaaaaa);
    adv("R5 alt path", 32'h18);
    adv("R6 arrive", 32'h200);
    step("R7 adv ignored", 1'b0, 1'b1, '0, '0, '0, '0, 32'h555);
    @(negedge clk);
    direct("R12 rejoined", mask_o == '1, 64'(mask_o), 64'hffffffff);
    adv("R8 normal", 32'h204);

    // R9 nested, distinct join PCs
    br("R9 outer", 32'h0000_ffff, 32'h300, 32'h304, 32'h400);
    br("R9 inner", 32'h0000_00ff, 32'h310, 32'h314, 32'h380);
    adv("R9 inner arrive", 32'h380);
    idle("R9 inner switch");
    adv("R9 inner back", 32'h380);
    idle("R9 inner pop");
    adv("R9 outer arrive", 32'h400);
    idle("R9 outer switch");
    adv("R9 outer back", 32'h400);
    idle("R9 outer pop");
    idle("R9 settled");

    // R9 if-only and shared join PC
    br("R9 if-only outer", 32'h0f0f_0f0f, 32'h600, 32'h500, 32'h500);
    br("R9 if-only inner", 32'h0000_000f, 32'h610, 32'h500, 32'h500);
    adv("R9 shared arrive", 32'h500);
    for (int k = 0; k < 6; k++) idle("R9 shared unwind");

    // R10 overflow
    for (int k = 0; k < D; k++)
      br("R10 fill", ~(32'h1 << k), 32'h800 + 32'(k), 32'hc00 + 32'(k), 32'h1000 + 32'(k * 16));
    br("R10 overflow", ~(32'h1 << D), 32'h900, 32'h904, 32'h2000);
    idle("R10 sticky");
    for (int k = D - 1; k >= 0; k--) begin
      adv("R10 unwind", 32'h1000 + 32'(k * 16));
      idle("R10 unwind switch");
      adv("R10 unwind back", 32'h1000 + 32'(k * 16));
      idle("R10 unwind pop");
    end
    idle("R10 restored");
    @(negedge clk);
    direct("R10 full mask after unwind", mask_o == '1, 64'(mask_o), 64'hffffffff);
    direct("R10 flag held", overflow_o == 1'b1, 64'(overflow_o), 64'h1);

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule